// File: doc/BRIEF.md
# Keyed Configuration Port with Peripheral Decode

This block is the configuration front end of a multi-function I/O controller that sits on an 8-bit, ISA-style I/O bus. A shared index port at 0x3F0 normally belongs to the floppy block. Writing an unlock key to it switches the block into configuration mode. While that mode is active, the index port and a data port at 0x3F1 together give access to sixteen 8-bit setup registers. A second key written to the index port ends configuration mode.

The stored setup fields drive the chip-select decode for five peripherals: an IDE command window, a floppy controller, a parallel port and two UARTs. Each peripheral can be enabled, disabled or moved between legacy base addresses. The block produces only the registered select strobes and the read data of the data port. The peripherals themselves sit outside it.

Top module: `cfg_port_decoder`

## Requirements
- R1: After reset the block is in normal mode (`cfg_active`=0). The setup registers hold these values: index 0 = 0x11, index 1 = 0x01, index 2 = 0x54, and every other writable index = 0x00. With these values, IDE is at 0x1F0, floppy at 0x3F0, parallel at 0x3BC, UART0 at 0x3F8 and UART1 at 0x2F8.
- R2: In normal mode, a write of 0x55 to address 0x3F0 enters configuration mode. A write of any other value to 0x3F0 leaves the mode unchanged.
- R3: In configuration mode, a write of 0xAA to 0x3F0 returns the block to normal mode. A write of any other value to 0x3F0 latches its low nibble as the register index. The index is cleared to 0 each time configuration mode is entered.
- R4: In configuration mode, `io_rdata` shows the indexed register whenever `io_addr`=0x3F1. A write to 0x3F1 stores `io_wdata` into that register, and the new value is visible from the next cycle.
- R5: In normal mode, a write to 0x3F1 changes no register, and `io_rdata` is 0xFF at every address. In configuration mode, `io_rdata` is 0xFF at every address other than 0x3F1.
- R6: Index 0xD always reads 0x65 and index 0xE always reads the revision value (0x01 by default). Writes to these two indices are discarded.
- R7: The IDE select covers an 8-byte window. It is enabled by bit 0 of register 0. The window is at base 0x170 when bit 1 of register 5 is set, and at 0x1F0 otherwise.
- R8: The floppy select covers an 8-byte window. It is enabled by bit 4 of register 0. The window is at base 0x370 when bit 0 of register 5 is set, and at 0x3F0 otherwise. In configuration mode, accesses to 0x3F0 and 0x3F1 never assert the floppy select.
- R9: Bits [1:0] of register 1 set the parallel select: 0 disables it, 1 gives a 4-byte window at 0x3BC, 2 gives an 8-byte window at 0x378, and 3 gives an 8-byte window at 0x278.
- R10: Register 2 sets up the two UARTs. For UART0, bits [1:0] pick the slot and bit 2 enables it. For UART1, bits [5:4] pick the slot and bit 6 enables it. Slots 0 to 3 place an 8-byte window at 0x3F8, 0x2F8, 0x338 and 0x238 respectively.
- R11: Each select is a registered strobe. It is high in the cycle after a cycle in which `io_rd` or `io_wr` was high with an address inside its window, and the decode uses the setup values held before that access. After a cycle with no access, all selects are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | 16 | I/O address |
| io_rd | input | 1 | Read strobe |
| io_wr | input | 1 | Write strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Data port read value, 0xFF when not driven |
| cfg_active | output | 1 | High while configuration mode is active |
| sel_ide | output | 1 | IDE command window select |
| sel_fdc | output | 1 | Floppy window select |
| sel_lpt | output | 1 | Parallel port select |
| sel_uart | output | 2 | UART selects, bit 0 for UART0 and bit 1 for UART1 |

## Verification
The bench builds the block with its default parameters: keys 0x55 and 0xAA, ports 0x3F0 and 0x3F1, ID 0x65 and revision 0x01. With these defaults, the floppy window at its primary base overlaps the configuration ports, so the claim rule for those ports can be checked both inside and outside configuration mode. Because every key and address is the legacy default, a random address walk over 0x160 to 0x3FF reaches every decode window, including the edges of the 4-byte parallel window. The same walk also produces random writes that unlock, reprogram and relock the block at unplanned moments.

// File: rtl/pio_cfg_pkg.sv
package pio_cfg_pkg;

    localparam int IO_ADDR_W  = 16;
    localparam int DATA_W     = 8;
    localparam int IDX_W      = 4;
    localparam int NREG       = 1 << IDX_W;
    localparam int NUM_UART   = 2;
    localparam int SLOT_W     = 2;

    localparam int IDE_SPAN_LG  = 3;
    localparam int FDC_SPAN_LG  = 3;
    localparam int UART_SPAN_LG = 3;
    localparam int LPT_NARROW_LG = 2;
    localparam int LPT_WIDE_LG   = 3;

    localparam int IDX_ID  = 13;
    localparam int IDX_REV = 14;

    typedef logic [IO_ADDR_W-1:0] ioaddr_t;
    typedef logic [DATA_W-1:0]    byte_t;

    typedef enum logic {
        MODE_RUN = 1'b0,
        MODE_CFG = 1'b1
    } cfg_mode_e;

    typedef struct packed {
        logic                              ide_en;
        logic                              ide_alt;
        logic                              fdc_en;
        logic                              fdc_alt;
        logic [1:0]                        lpt_pick;
        logic [NUM_UART-1:0]               uart_en;
        logic [NUM_UART-1:0][SLOT_W-1:0]   uart_slot;
    } dec_cfg_t;

    typedef struct packed {
        logic [NUM_UART-1:0] uart;
        logic                lpt;
        logic                fdc;
        logic                ide;
    } sel_t;

    function automatic byte_t reg_reset(int unsigned idx);
        case (idx)
            0:       return 8'h11;
            1:       return 8'h01;
            2:       return 8'h54;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic is_read_only(int unsigned idx);
        return (idx == IDX_ID) || (idx == IDX_REV);
    endfunction

    function automatic ioaddr_t com_base(logic [SLOT_W-1:0] slot);
        case (slot)
            2'd0:    return 16'h03F8;
            2'd1:    return 16'h02F8;
            2'd2:    return 16'h0338;
            default: return 16'h0238;
        endcase
    endfunction

    function automatic logic in_win(ioaddr_t a, ioaddr_t base, int unsigned lg);
        return (a >> lg) == (base >> lg);
    endfunction

endpackage

// File: rtl/cfg_keylock.sv
module cfg_keylock
    import pio_cfg_pkg::*;
#(
    parameter byte_t   KEY_ENTER  = 8'h55,
    parameter byte_t   KEY_EXIT   = 8'hAA,
    parameter ioaddr_t INDEX_PORT = 16'h03F0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             acc_wr,
    input  ioaddr_t          acc_addr,
    input  byte_t            acc_wdata,
    output cfg_mode_e        mode,
    output logic [IDX_W-1:0] index
);

    logic idx_wr;
    assign idx_wr = acc_wr && (acc_addr == INDEX_PORT);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode  <= MODE_RUN;
            index <= '0;
        end else if (idx_wr) begin
            case (mode)
                MODE_RUN: begin
                    if (acc_wdata == KEY_ENTER) begin
                        mode  <= MODE_CFG;
                        index <= '0;
                    end
                end
                default: begin
                    if (acc_wdata == KEY_EXIT) mode <= MODE_RUN;
                    else                       index <= acc_wdata[IDX_W-1:0];
                end
            endcase
        end
    end

    assert_enter_R2: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_RUN && idx_wr && acc_wdata == KEY_ENTER) |=> (mode == MODE_CFG && index == '0));

    assert_exit_R3: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_CFG && idx_wr && acc_wdata == KEY_EXIT) |=> (mode == MODE_RUN));

    assert_mode_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (!idx_wr) |=> $stable(mode));

endmodule

// File: rtl/cfg_regfile.sv
module cfg_regfile
    import pio_cfg_pkg::*;
#(
    parameter byte_t   ID_VALUE  = 8'h65,
    parameter byte_t   REV_VALUE = 8'h01,
    parameter ioaddr_t DATA_PORT = 16'h03F1
) (
    input  logic             clk,
    input  logic             rst,
    input  cfg_mode_e        mode,
    input  logic [IDX_W-1:0] index,
    input  logic             acc_wr,
    input  ioaddr_t          acc_addr,
    input  byte_t            acc_wdata,
    output byte_t            rd_data,
    output dec_cfg_t         dcfg
);

    byte_t reg_view [NREG];
    logic  data_hit;
    logic  data_wr;

    assign data_hit = (mode == MODE_CFG) && (acc_addr == DATA_PORT);
    assign data_wr  = data_hit && acc_wr;

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        if (is_read_only(i)) begin : g_ro
            assign reg_view[i] = (i == IDX_ID) ? ID_VALUE : REV_VALUE;
        end else begin : g_rw
            byte_t q;
            always_ff @(posedge clk) begin
                if (rst)                                  q <= reg_reset(i);
                else if (data_wr && index == IDX_W'(i))   q <= acc_wdata;
            end
            assign reg_view[i] = q;
        end
    end

    assign rd_data = data_hit ? reg_view[index] : 8'hFF;

    always_comb begin
        dcfg              = '0;
        dcfg.ide_en       = reg_view[0][0];
        dcfg.fdc_en       = reg_view[0][4];
        dcfg.fdc_alt      = reg_view[5][0];
        dcfg.ide_alt      = reg_view[5][1];
        dcfg.lpt_pick     = reg_view[1][1:0];
        dcfg.uart_slot[0] = reg_view[2][1:0];
        dcfg.uart_en[0]   = reg_view[2][2];
        dcfg.uart_slot[1] = reg_view[2][5:4];
        dcfg.uart_en[1]   = reg_view[2][6];
    end

    assert_locked_R5: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_RUN) |=> $stable(dcfg));

    assert_id_fixed_R6: assert property (@(posedge clk) disable iff (rst)
        (data_hit && index == IDX_W'(IDX_ID)) |-> (rd_data == ID_VALUE));

endmodule

// File: rtl/cfg_window_decode.sv
module cfg_window_decode
    import pio_cfg_pkg::*;
#(
    parameter ioaddr_t INDEX_PORT = 16'h03F0,
    parameter ioaddr_t DATA_PORT  = 16'h03F1,
    parameter ioaddr_t IDE_PRI    = 16'h01F0,
    parameter ioaddr_t IDE_SEC    = 16'h0170,
    parameter ioaddr_t FDC_PRI    = 16'h03F0,
    parameter ioaddr_t FDC_SEC    = 16'h0370
) (
    input  logic      clk,
    input  logic      rst,
    input  cfg_mode_e mode,
    input  dec_cfg_t  dcfg,
    input  logic      acc_rd,
    input  logic      acc_wr,
    input  ioaddr_t   acc_addr,
    output sel_t      sel
);

    logic access;
    logic claimed;
    sel_t hit;

    assign access  = acc_rd || acc_wr;
    assign claimed = (mode == MODE_CFG) &&
                     ((acc_addr == INDEX_PORT) || (acc_addr == DATA_PORT));

    always_comb begin
        hit.ide = access && dcfg.ide_en &&
                  in_win(acc_addr, dcfg.ide_alt ? IDE_SEC : IDE_PRI, IDE_SPAN_LG);
        hit.fdc = access && dcfg.fdc_en && !claimed &&
                  in_win(acc_addr, dcfg.fdc_alt ? FDC_SEC : FDC_PRI, FDC_SPAN_LG);
        case (dcfg.lpt_pick)
            2'd1:    hit.lpt = access && in_win(acc_addr, 16'h03BC, LPT_NARROW_LG);
            2'd2:    hit.lpt = access && in_win(acc_addr, 16'h0378, LPT_WIDE_LG);
            2'd3:    hit.lpt = access && in_win(acc_addr, 16'h0278, LPT_WIDE_LG);
            default: hit.lpt = 1'b0;
        endcase
    end

    for (genvar u = 0; u < NUM_UART; u++) begin : g_uart
        assign hit.uart[u] = access && dcfg.uart_en[u] &&
                             in_win(acc_addr, com_base(dcfg.uart_slot[u]), UART_SPAN_LG);
    end

    always_ff @(posedge clk) begin
        if (rst) sel <= '0;
        else     sel <= hit;
    end

    assert_idle_R11: assert property (@(posedge clk) disable iff (rst)
        (!access) |=> (sel == '0));

    assert_claim_R8: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_CFG && (acc_addr == INDEX_PORT || acc_addr == DATA_PORT)) |=> !sel.fdc);

    assert_lpt_off_R9: assert property (@(posedge clk) disable iff (rst)
        (dcfg.lpt_pick == 2'd0) |=> !sel.lpt);

endmodule

// File: rtl/cfg_port_decoder.sv
module cfg_port_decoder
    import pio_cfg_pkg::*;
#(
    parameter byte_t   KEY_ENTER  = 8'h55,
    parameter byte_t   KEY_EXIT   = 8'hAA,
    parameter ioaddr_t INDEX_PORT = 16'h03F0,
    parameter ioaddr_t DATA_PORT  = 16'h03F1,
    parameter byte_t   ID_VALUE   = 8'h65,
    parameter byte_t   REV_VALUE  = 8'h01
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [15:0]          io_addr,
    input  logic                 io_rd,
    input  logic                 io_wr,
    input  logic [7:0]           io_wdata,
    output logic [7:0]           io_rdata,
    output logic                 cfg_active,
    output logic                 sel_ide,
    output logic                 sel_fdc,
    output logic                 sel_lpt,
    output logic [1:0]           sel_uart
);

    cfg_mode_e        mode;
    logic [IDX_W-1:0] index;
    dec_cfg_t         dcfg;
    sel_t             sel;

    cfg_keylock #(
        .KEY_ENTER (KEY_ENTER),
        .KEY_EXIT  (KEY_EXIT),
        .INDEX_PORT(INDEX_PORT)
    ) u_lock (
        .clk      (clk),
        .rst      (rst),
        .acc_wr   (io_wr),
        .acc_addr (io_addr),
        .acc_wdata(io_wdata),
        .mode     (mode),
        .index    (index)
    );

    cfg_regfile #(
        .ID_VALUE (ID_VALUE),
        .REV_VALUE(REV_VALUE),
        .DATA_PORT(DATA_PORT)
    ) u_regs (
        .clk      (clk),
        .rst      (rst),
        .mode     (mode),
        .index    (index),
        .acc_wr   (io_wr),
        .acc_addr (io_addr),
        .acc_wdata(io_wdata),
        .rd_data  (io_rdata),
        .dcfg     (dcfg)
    );

    cfg_window_decode #(
        .INDEX_PORT(INDEX_PORT),
        .DATA_PORT (DATA_PORT)
    ) u_dec (
        .clk     (clk),
        .rst     (rst),
        .mode    (mode),
        .dcfg    (dcfg),
        .acc_rd  (io_rd),
        .acc_wr  (io_wr),
        .acc_addr(io_addr),
        .sel     (sel)
    );

    assign cfg_active = (mode == MODE_CFG);
    assign sel_ide    = sel.ide;
    assign sel_fdc    = sel.fdc;
    assign sel_lpt    = sel.lpt;
    assign sel_uart   = sel.uart;

endmodule

// File: tb/sim_cfg_port_decoder.sv
`timescale 1ns/100ps
module sim_cfg_port_decoder;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] io_addr = '0;
    logic        io_rd = 1'b0;
    logic        io_wr = 1'b0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  io_rdata;
    logic        cfg_active;
    logic        sel_ide, sel_fdc, sel_lpt;
    logic [1:0]  sel_uart;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    cfg_port_decoder u0 (
        .clk(clk), .rst(rst), .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .cfg_active(cfg_active),
        .sel_ide(sel_ide), .sel_fdc(sel_fdc), .sel_lpt(sel_lpt), .sel_uart(sel_uart)
    );

    // ---------------- behavioural reference model ----------------
    int m_mode;
    int m_idx;
    int m_regs [16];
    int exp_sel;
    int prev_acc;
    int coms [4] = '{'h3F8, 'h2F8, 'h338, 'h238};

    function automatic bit inside_rng(int a, int base, int size);
        return (a >= base) && (a < base + size);
    endfunction

    function automatic int model_sel(int a, bit acc);
        int r = 0;
        int base;
        if (!acc) return 0;
        base = m_regs[5][1] ? 'h170 : 'h1F0;
        if (m_regs[0][0] && inside_rng(a, base, 8)) r |= 1;
        base = m_regs[5][0] ? 'h370 : 'h3F0;
        if (m_regs[0][4] && inside_rng(a, base, 8) &&
            !(m_mode == 1 && (a == 'h3F0 || a == 'h3F1))) r |= 2;
        case (m_regs[1] & 3)
            1: if (inside_rng(a, 'h3BC, 4)) r |= 4;
            2: if (inside_rng(a, 'h378, 8)) r |= 4;
            3: if (inside_rng(a, 'h278, 8)) r |= 4;
            default: ;
        endcase
        if (m_regs[2][2] && inside_rng(a, coms[m_regs[2] & 3], 8)) r |= 8;
        if (m_regs[2][6] && inside_rng(a, coms[(m_regs[2] >> 4) & 3], 8)) r |= 16;
        return r;
    endfunction

    function automatic int model_rdata(int a);
        if (m_mode == 1 && a == 'h3F1) begin
            if (m_idx == 13) return 'h65;
            if (m_idx == 14) return 'h01;
            return m_regs[m_idx];
        end
        return 'hFF;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_mode = 0; m_idx = 0; exp_sel = 0; prev_acc = 0;
            for (int i = 0; i < 16; i++) m_regs[i] = 0;
            m_regs[0] = 'h11; m_regs[1] = 'h01; m_regs[2] = 'h54;
        end else begin
            exp_sel  = model_sel(int'(io_addr), io_rd || io_wr);
            prev_acc = (io_rd || io_wr) ? 1 : 0;
            if (io_wr) begin
                if (io_addr == 16'h3F0) begin
                    if (m_mode == 0) begin
                        if (io_wdata == 8'h55) begin m_mode = 1; m_idx = 0; end
                    end else if (io_wdata == 8'hAA) m_mode = 0;
                    else m_idx = int'(io_wdata) & 15;
                end else if (io_addr == 16'h3F1 && m_mode == 1 && m_idx != 13 && m_idx != 14) begin
                    m_regs[m_idx] = int'(io_wdata);
                end
            end
        end
    end

    task automatic chk(string tag, int got, int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s got=%0h exp=%0h at %0t", tag, got, exp, $time);
        end
    endtask

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (!rst) begin
            chk("R2 R3 mode", int'(cfg_active), m_mode);
            if (m_mode == 1 && io_addr == 16'h3F1 && (m_idx == 13 || m_idx == 14))
                chk("R6 rdata", int'(io_rdata), model_rdata(int'(io_addr)));
            else if (m_mode == 1)
                chk("R4 rdata", int'(io_rdata), model_rdata(int'(io_addr)));
            else
                chk("R5 rdata", int'(io_rdata), model_rdata(int'(io_addr)));
            if (prev_acc == 0)
                chk("R11 idle sel", int'({sel_uart, sel_lpt, sel_fdc, sel_ide}), 0);
            else begin
                chk("R7 sel_ide",  int'(sel_ide),  exp_sel & 1);
                chk("R8 sel_fdc",  int'(sel_fdc),  (exp_sel >> 1) & 1);
                chk("R9 sel_lpt",  int'(sel_lpt),  (exp_sel >> 2) & 1);
                chk("R10 sel_uart", int'(sel_uart), (exp_sel >> 3) & 3);
            end
        end
    end

    // ---------------- stimulus ----------------
    task automatic cyc(int a, bit rd, bit wr, int d);
        @(posedge clk); #1;
        io_addr = 16'(a); io_rd = rd; io_wr = wr; io_wdata = 8'(d);
    endtask

    task automatic idle();
        cyc(0, 0, 0, 0);
    endtask

    task automatic wr_port(int a, int d);
        cyc(a, 0, 1, d);
    endtask

    task automatic rd_expect(string tag, int a, int exp);
        cyc(a, 1, 0, 0);
        @(negedge clk);
        chk(tag, int'(io_rdata), exp);
    endtask

    task automatic sel_expect(string tag, int a, int exp);
        cyc(a, 1, 0, 0);
        idle();
        @(negedge clk);
        chk(tag, int'({sel_uart, sel_lpt, sel_fdc, sel_ide}), exp);
    endtask

    task automatic set_reg(int idx, int val);
        wr_port('h3F0, idx);
        wr_port('h3F1, val);
    endtask

    initial begin : watchdog
        #(200000 * 5);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        idle();
        @(negedge clk);
        chk("R1 reset mode", int'(cfg_active), 0);
        rd_expect("R1 R5 data port locked", 'h3F1, 'hFF);
        sel_expect("R1 default ide", 'h1F0, 1);
        sel_expect("R1 default fdc", 'h3F5, 2);
        sel_expect("R1 default lpt", 'h3BC, 4);
        sel_expect("R1 default uart0", 'h3F8, 8);
        sel_expect("R1 default uart1", 'h2FF, 16);

        wr_port('h3F1, 'h00);                       // ignored in normal mode
        wr_port('h3F0, 'h12);
        idle();
        @(negedge clk);
        chk("R2 non-key stays locked", int'(cfg_active), 0);
        wr_port('h3F0, 'h55);
        idle();
        @(negedge clk);
        chk("R2 key unlocks", int'(cfg_active), 1);
        rd_expect("R1 R3 index zero reg0", 'h3F1, 'h11);
        wr_port('h3F0, 1);  rd_expect("R1 reg1", 'h3F1, 'h01);
        wr_port('h3F0, 2);  rd_expect("R1 reg2", 'h3F1, 'h54);
        wr_port('h3F0, 5);  rd_expect("R1 reg5", 'h3F1, 'h00);
        wr_port('h3F0, 'hFD); rd_expect("R3 R6 id", 'h3F1, 'h65);
        wr_port('h3F1, 'h00); rd_expect("R6 id after write", 'h3F1, 'h65);
        wr_port('h3F0, 'hE);  wr_port('h3F1, 'h77); rd_expect("R6 rev", 'h3F1, 'h01);
        set_reg('hF, 'h5A);   rd_expect("R4 readback", 'h3F1, 'h5A);
        rd_expect("R5 other addr in cfg", 'h3F0, 'hFF);
        sel_expect("R8 claim data port", 'h3F1, 0);
        sel_expect("R8 fdc rest of window", 'h3F2, 2);

        set_reg(5, 3);
        set_reg(1, 2);
        set_reg(2, 'h4B);
        wr_port('h3F0, 'hAA);
        idle();
        @(negedge clk);
        chk("R3 exit key", int'(cfg_active), 0);
        sel_expect("R7 ide secondary", 'h177, 1);
        sel_expect("R7 ide primary off", 'h1F0, 0);
        sel_expect("R8 fdc secondary", 'h370, 2);
        sel_expect("R9 lpt 378 top", 'h37F, 4);
        sel_expect("R10 uart1 com1 uart0 off", 'h3F8, 16);
        sel_expect("R10 uart0 disabled", 'h238, 0);

        wr_port('h3F1, 'h99);                         // ignored
        wr_port('h3F0, 'h55);
        wr_port('h3F0, 'hF);
        rd_expect("R5 write ignored when locked", 'h3F1, 'h5A);
        set_reg(1, 1);
        set_reg(0, 0);
        wr_port('h3F0, 'hAA);
        sel_expect("R9 lpt narrow top", 'h3BF, 4);
        sel_expect("R9 lpt narrow beyond", 'h3C0, 0);
        sel_expect("R7 R8 both disabled", 'h370, 0);

        for (int p = 0; p < 8; p++) begin
            wr_port('h3F0, 'h55);
            set_reg(1, p & 3);
            set_reg(2, ((p & 3) << 4) | ((p + 1) & 3) | (p[0] ? 'h44 : 'h04));
            set_reg(0, p[1] ? 'h11 : 'h10);
            set_reg(5, p & 3);
            wr_port('h3F0, 'hAA);
            for (int k = 0; k < 300; k++) begin
                int a;
                int r;
                a = 'h160 + int'($urandom_range(0, 'h29F));
                r = int'($urandom_range(0, 9));
                if (r < 5)       cyc(a, 1, 0, 0);
                else if (r < 6)  cyc(a, 0, 1, int'($urandom_range(0, 255)));
                else if (r < 7)  cyc('h3F0, 0, 1, (r & 1) ? 'h55 : int'($urandom_range(0, 255)));
                else if (r < 8)  cyc('h3F1, 1, 0, 0);
                else             idle();
            end
            wr_port('h3F0, 'hAA);
            idle();
        end

        idle();
        @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule